// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps one private write-back cache coherent on a shared snooping bus. It holds a small direct-mapped array of lines. Each line has a tag, a one-word data field and one of four coherence states: Invalid, Shared, Exclusive or Modified. Processor reads and writes are looked up in the array. A hit is served locally. A miss, or a write to a shared copy, drives a bus command in the same cycle. Bus grant, the fill data and the copies-exist wire are all assumed to settle within that one cycle.

Transactions that other caches place on the bus come in through a snoop port. For each one, the block decides three things: whether to raise the copies-exist wire, whether to supply the line's data, and which state the line moves to. Dirty data is supplied with a Flush, which also updates memory. Clean data is supplied cache-to-cache with FlushOpt, which leaves memory alone. A snoop has priority over the processor: during a snoop cycle the processor port reports not-ready, and a request presented in that cycle is not taken.

Encodings used on the ports:
- Bus and snoop commands: 0 none, 1 BusRd, 2 BusRdX, 3 BusUpgr.
- Snoop replies: 0 none, 1 Flush, 2 FlushOpt.
- Addresses are word addresses. The line index is the address modulo LINES, and the tag is the address divided by LINES.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus command, write-back, reply, copies-exist or processor completion is asserted until a request arrives.
- R2: A read miss drives bus command 1 (BusRd) with the request address. The line is filled from bus_fill_data, as Exclusive when bus_copies_in is 0 and as Shared when it is 1.
- R3: A processor access is completed exactly one cycle after acceptance: cpu_done and cpu_hit pulse, and cpu_rdata holds the line's resulting word. A read hit in any valid state drives no bus command.
- R4: A write hit on an Exclusive line drives no bus command and leaves the line Modified.
- R5: A write hit on a Shared line drives bus command 3 (BusUpgr) and leaves the line Modified.
- R6: A write miss drives bus command 2 (BusRdX) and installs the line as Modified, holding the written word.
- R7: A miss whose victim is Modified drives wb_valid in the same cycle, with the victim's address and data. A miss whose victim is clean or Invalid drives no write-back.
- R8: A snooped BusRd hitting a Modified line replies 1 (Flush) with the line data and leaves the line Shared.
- R9: A snooped BusRd hitting an Exclusive or Shared line replies 2 (FlushOpt) with the line data and leaves the line Shared.
- R10: A snooped BusRdX hitting a valid line invalidates it. It replies Flush if the line was Modified and FlushOpt otherwise. A snooped BusUpgr invalidates a Shared or Exclusive line with no reply, and is never expected on a Modified line.
- R11: copies_out is 1 exactly when a snooped BusRd or BusRdX matches a valid line. A snoop that misses gives no reply and leaves the array unchanged.
- R12: While snp_valid is 1, cpu_ready is 0 and a processor request is ignored: no bus command, and no completion in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write word |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| cpu_done | output | 1 | Completion pulse, one cycle after acceptance |
| cpu_hit | output | 1 | Completed access was a hit |
| cpu_rdata | output | DW | Line word after the access |
| bus_req_cmd | output | 2 | Bus command issued this cycle |
| bus_req_addr | output | AW | Address of the bus command |
| bus_copies_in | input | 1 | Copies-exist wire seen by a read miss |
| bus_fill_data | input | DW | Data returned for a miss |
| wb_valid | output | 1 | Dirty victim written back this cycle |
| wb_addr | output | AW | Victim address |
| wb_data | output | DW | Victim data |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| copies_out | output | 1 | This cache drives copies-exist |
| snp_reply | output | 2 | Data reply kind |
| snp_data | output | DW | Data supplied on the bus |

## Verification
The bench probes the following corner cases and the failure each one would expose:
- Exclusive versus Shared fill. A controller that ignores the copies-exist wire would later drive BusUpgr on a silent Exclusive write, or stay silent on a Shared one.
- Victim eviction. A controller that wrote back clean victims would raise wb_valid wrongly; one that dropped dirty victims would lose the word.
- Snoops on a matching index with a different tag. A controller that compared only the index would assert copies_out or invalidate the wrong line.
- Colliding snoop and processor request. A controller that let the processor through would drive a bus command during another cache's transaction.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPGR = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_FLUSH    = 2'd1,
    RP_FLUSHOPT = 2'd2
  } snp_reply_t;

  function automatic logic is_valid(input line_state_t s);
    return s != LS_INV;
  endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 9,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_state_t      rd_state,
  output logic [TAG_W-1:0] rd_tag,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_state_t      wr_state,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [DW-1:0]    wr_data
);

  line_state_t      st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= LS_INV;
      end else if (sel) begin
        st_q[g] <= wr_state;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g] <= wr_tag;
        dat_q[g] <= wr_data;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];

endmodule

// File: rtl/mesi_cpu_policy.sv
module mesi_cpu_policy
  import mesi_pkg::*;
(
  input  line_state_t cur_state,
  input  logic        tag_eq,
  input  logic        we,
  input  logic        copies_in,
  output logic        hit,
  output bus_cmd_t    cmd,
  output line_state_t next_state,
  output logic        need_wb
);

  always_comb begin
    hit        = is_valid(cur_state) && tag_eq;
    cmd        = BC_NONE;
    next_state = cur_state;
    need_wb    = 1'b0;
    if (hit) begin
      if (we) begin
        next_state = LS_MOD;
        if (cur_state == LS_SHR) cmd = BC_UPGR;
      end
    end else begin
      need_wb = (cur_state == LS_MOD);
      if (we) begin
        cmd        = BC_RDX;
        next_state = LS_MOD;
      end else begin
        cmd        = BC_RD;
        next_state = copies_in ? LS_SHR : LS_EXC;
      end
    end
  end

endmodule

// File: rtl/mesi_snoop_policy.sv
module mesi_snoop_policy
  import mesi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  bus_cmd_t    cmd,
  input  line_state_t cur_state,
  input  logic        tag_eq,
  output logic        match,
  output logic        copies,
  output snp_reply_t  reply,
  output line_state_t next_state
);

  always_comb begin
    match      = valid && is_valid(cur_state) && tag_eq;
    copies     = 1'b0;
    reply      = RP_NONE;
    next_state = cur_state;
    if (match) begin
      unique case (cmd)
        BC_RD: begin
          copies     = 1'b1;
          reply      = (cur_state == LS_MOD) ? RP_FLUSH : RP_FLUSHOPT;
          next_state = LS_SHR;
        end
        BC_RDX: begin
          copies     = 1'b1;
          reply      = (cur_state == LS_MOD) ? RP_FLUSH : RP_FLUSHOPT;
          next_state = LS_INV;
        end
        BC_UPGR: begin
          reply      = (cur_state == LS_MOD) ? RP_FLUSH : RP_NONE;
          next_state = LS_INV;
        end
        default: ;
      endcase
    end
  end

  // R10
  upgr_never_on_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cmd == BC_UPGR) |-> cur_state != LS_MOD);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = AW - IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic          cpu_hit,
  output logic [DW-1:0] cpu_rdata,
  output logic [1:0]    bus_req_cmd,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_copies_in,
  input  logic [DW-1:0] bus_fill_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          copies_out,
  output logic [1:0]    snp_reply,
  output logic [DW-1:0] snp_data
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [AW-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IDX_W];
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [TAG_W-1:0] t,
                                              input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  // Named internal events
  logic             accept;
  logic [IDX_W-1:0] look_idx;
  logic [TAG_W-1:0] look_tag;
  logic             tag_eq;
  line_state_t      rd_state;
  logic [TAG_W-1:0] rd_tag;
  logic [DW-1:0]    rd_data;

  logic             p_hit;
  bus_cmd_t         p_cmd;
  line_state_t      p_next;
  logic             p_wb;
  logic [DW-1:0]    p_word;

  logic             s_match;
  logic             s_copies;
  snp_reply_t       s_reply;
  line_state_t      s_next;

  logic             wr_en;
  line_state_t      wr_state;
  logic [TAG_W-1:0] wr_tag;
  logic [DW-1:0]    wr_data;

  assign accept   = cpu_req && !snp_valid;
  assign look_idx = snp_valid ? idx_of(snp_addr) : idx_of(cpu_addr);
  assign look_tag = snp_valid ? tag_of(snp_addr) : tag_of(cpu_addr);
  assign tag_eq   = (rd_tag == look_tag);

  mesi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_state (rd_state),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_idx   (look_idx),
    .wr_state (wr_state),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  mesi_cpu_policy u_cpu (
    .cur_state  (rd_state),
    .tag_eq     (tag_eq),
    .we         (cpu_we),
    .copies_in  (bus_copies_in),
    .hit        (p_hit),
    .cmd        (p_cmd),
    .next_state (p_next),
    .need_wb    (p_wb)
  );

  mesi_snoop_policy u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (snp_valid),
    .cmd        (bus_cmd_t'(snp_cmd)),
    .cur_state  (rd_state),
    .tag_eq     (tag_eq),
    .match      (s_match),
    .copies     (s_copies),
    .reply      (s_reply),
    .next_state (s_next)
  );

  // Word the line holds after the processor access
  always_comb begin
    if (cpu_we)     p_word = cpu_wdata;
    else if (p_hit) p_word = rd_data;
    else            p_word = bus_fill_data;
  end

  // Array update: snoop side wins the cycle
  always_comb begin
    wr_en    = 1'b0;
    wr_state = rd_state;
    wr_tag   = rd_tag;
    wr_data  = rd_data;
    if (s_match) begin
      wr_en    = 1'b1;
      wr_state = s_next;
    end else if (accept) begin
      wr_en    = 1'b1;
      wr_state = p_next;
      wr_tag   = tag_of(cpu_addr);
      wr_data  = p_word;
    end
  end

  assign cpu_ready    = !snp_valid;
  assign bus_req_cmd  = accept ? p_cmd : BC_NONE;
  assign bus_req_addr = cpu_addr;
  assign wb_valid     = accept && p_wb;
  assign wb_addr      = join_addr(rd_tag, look_idx);
  assign wb_data      = rd_data;
  assign copies_out   = s_copies;
  assign snp_reply    = s_reply;
  assign snp_data     = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= accept;
      cpu_hit  <= accept && p_hit;
      if (accept) cpu_rdata <= p_word;
    end
  end

  // R12
  no_bus_during_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (bus_req_cmd == BC_NONE && !wb_valid));

  // R3
  done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cpu_done);

  // R3
  no_done_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !cpu_done);

  // R7
  wb_pairs_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (bus_req_cmd == BC_RD || bus_req_cmd == BC_RDX));

  // R5
  upgr_only_on_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_cmd == BC_UPGR) |-> (tag_eq && rd_state == LS_SHR));

  // R11
  reply_needs_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_reply != RP_NONE && snp_cmd != BC_UPGR) |-> copies_out);

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_done, cpu_hit;
  logic [DW-1:0] cpu_rdata;
  logic [1:0]    bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic          bus_copies_in = 1'b0;
  logic [DW-1:0] bus_fill_data = '0;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          copies_out;
  logic [1:0]    snp_reply;
  logic [DW-1:0] snp_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model: 0 invalid, 1 shared, 2 exclusive, 3 modified
  int          m_st  [NL];
  int          m_tag [NL];
  logic [31:0] m_dat [NL];

  always #4 clk = ~clk;

  mesi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_copies_in(bus_copies_in), .bus_fill_data(bus_fill_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .copies_out(copies_out), .snp_reply(snp_reply), .snp_data(snp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic cpu_op(input bit we, input int addr, input logic [31:0] wd,
                        input bit cin, input logic [31:0] fill, input string req);
    int idx, tg, exp_cmd, nst;
    bit hit, exp_wb;
    logic [31:0] word;
    idx = addr % NL;
    tg  = addr / NL;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
    bus_copies_in = cin; bus_fill_data = fill;
    hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    exp_wb = !hit && (m_st[idx] == 3);
    if (hit) begin
      exp_cmd = (we && m_st[idx] == 1) ? 3 : 0;
      nst = we ? 3 : m_st[idx];
      word = we ? wd : m_dat[idx];
    end else begin
      exp_cmd = we ? 2 : 1;
      nst = we ? 3 : (cin ? 1 : 2);
      word = we ? wd : fill;
    end
    #1;
    chk(req, "cpu_ready", cpu_ready, 1);
    chk(req, "bus_req_cmd", bus_req_cmd, exp_cmd);
    if (exp_cmd != 0) chk(req, "bus_req_addr", bus_req_addr, addr);
    chk(req, "wb_valid", wb_valid, exp_wb);
    if (exp_wb) begin
      chk(req, "wb_addr", wb_addr, m_tag[idx] * NL + idx);
      chk(req, "wb_data", wb_data, m_dat[idx]);
    end
    @(posedge clk);
    #1;
    cpu_req = 0;
    m_st[idx] = nst; m_tag[idx] = tg; m_dat[idx] = word;
    chk(req, "cpu_done", cpu_done, 1);
    chk(req, "cpu_hit", cpu_hit, hit);
    chk(req, "cpu_rdata", cpu_rdata, word);
  endtask

  task automatic snoop_op(input int cmd, input int addr, input bit with_cpu, input string req);
    int idx, tg, exp_rep;
    bit hit, exp_cp;
    idx = addr % NL;
    tg  = addr / NL;
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = AW'(addr);
    if (with_cpu) begin
      cpu_req = 1; cpu_we = 1; cpu_addr = AW'(addr + 1); cpu_wdata = 32'hDEAD;
    end
    hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    exp_cp = hit && (cmd == 1 || cmd == 2);
    exp_rep = 0;
    if (exp_cp) exp_rep = (m_st[idx] == 3) ? 1 : 2;
    else if (hit && cmd == 3 && m_st[idx] == 3) exp_rep = 1;
    #1;
    chk(req, "copies_out", copies_out, exp_cp);
    chk(req, "snp_reply", snp_reply, exp_rep);
    if (exp_rep != 0) chk(req, "snp_data", snp_data, m_dat[idx]);
    if (with_cpu) begin
      chk(req, "cpu_ready in snoop", cpu_ready, 0);
      chk(req, "bus_req_cmd in snoop", bus_req_cmd, 0);
    end
    @(posedge clk);
    #1;
    snp_valid = 0; cpu_req = 0;
    if (hit) m_st[idx] = (cmd == 1) ? 1 : ((cmd == 0) ? m_st[idx] : 0);
    if (with_cpu) chk(req, "cpu_done after snoop", cpu_done, 0);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    #1;
    chk(req, "idle bus_req_cmd", bus_req_cmd, 0);
    chk(req, "idle wb_valid", wb_valid, 0);
    chk(req, "idle copies_out", copies_out, 0);
    chk(req, "idle snp_reply", snp_reply, 0);
    @(posedge clk);
    #1;
    chk(req, "idle cpu_done", cpu_done, 0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset cpu_done", cpu_done, 0);
    chk("R1", "reset bus_req_cmd", bus_req_cmd, 0);
    chk("R1", "reset wb_valid", wb_valid, 0);
    @(negedge clk);
    rst_n = 1;
    idle("R1");
    // R1: every line starts Invalid, so a snoop to each index misses
    for (int i = 0; i < NL; i++) snoop_op(1, i, 0, "R1");

    cpu_op(0, 'h010, 0, 0, 32'hA1, "R2");      // read miss -> Exclusive
    cpu_op(0, 'h010, 0, 1, 32'h0, "R3");       // read hit
    cpu_op(1, 'h010, 32'hB1, 0, 0, "R4");      // silent write, E->M
    snoop_op(1, 'h010, 0, "R8");               // Flush, M->S
    cpu_op(1, 'h010, 32'hC1, 0, 0, "R8");      // now Shared -> BusUpgr
    cpu_op(0, 'h021, 0, 1, 32'hD2, "R2");      // read miss with copies -> Shared
    cpu_op(1, 'h021, 32'hD3, 0, 0, "R5");      // BusUpgr, S->M
    cpu_op(0, 'h032, 0, 0, 32'hE3, "R2");      // Exclusive
    snoop_op(1, 'h032, 0, "R9");               // FlushOpt, E->S
    snoop_op(1, 'h032, 0, "R9");               // FlushOpt from S
    cpu_op(1, 'h032, 32'hE4, 0, 0, "R5");      // S->M via BusUpgr
    snoop_op(1, 'h03A, 0, "R11");              // same index, other tag
    snoop_op(2, 'h03A, 0, "R11");
    cpu_op(0, 'h032, 0, 0, 0, "R11");          // still hit, data kept
    cpu_op(0, 'h018, 0, 0, 32'hF0, "R7");      // dirty victim written back
    cpu_op(0, 'h020, 0, 0, 32'hF1, "R7");      // clean victim, silent
    cpu_op(1, 'h045, 32'h45, 0, 32'h99, "R6"); // write miss -> M
    cpu_op(0, 'h045, 0, 0, 0, "R6");
    cpu_op(1, 'h04D, 32'h4D, 0, 0, "R7");      // write miss, dirty victim
    snoop_op(2, 'h04D, 0, "R10");              // Flush then invalid
    cpu_op(0, 'h04D, 0, 0, 32'h77, "R10");     // misses again
    cpu_op(0, 'h056, 0, 1, 32'h56, "R10");     // Shared
    snoop_op(3, 'h056, 0, "R10");              // BusUpgr invalidates
    cpu_op(0, 'h056, 0, 0, 32'h57, "R10");
    cpu_op(0, 'h067, 0, 0, 32'h67, "R10");     // Exclusive
    snoop_op(2, 'h067, 0, "R10");              // FlushOpt then invalid
    cpu_op(0, 'h067, 0, 1, 32'h68, "R10");
    snoop_op(1, 'h021, 1, "R12");              // collision: cpu blocked
    cpu_op(0, 'h022, 0, 0, 32'h22, "R12");     // blocked write left no trace
    snoop_op(1, 'h022, 0, "R12");
    idle("R3");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule